// File: doc/BRIEF.md
# Two-Cluster Reloadable Clock Divider

This block derives one clock-enable stream per processor cluster from a shared PLL clock. Each stream pulses high for one PLL cycle out of every N cycles, where N is the integer ratio in effect for that cluster. Software programs a new ratio into a shadow field through a word-addressed register port. Writing the shadow field has no effect on the output by itself. The new ratio takes effect only after software raises a reload request.

Each cluster has a small state machine with four states. In DV_RUN the ratio in effect is steady and the cluster's stable flag is high. A rising edge of the reload request moves it from DV_RUN to DV_ARMED. The rising edge also latches the clamped shadow ratio as the pending ratio and lowers the stable flag. In DV_ARMED the machine waits for the last cycle of the current output period. At that point it commits the pending ratio, restarts the period counter and moves to DV_SETTLE_A. If the force-reload flag is set, it commits in the first DV_ARMED cycle instead. The machine then steps unconditionally to DV_SETTLE_B and back to DV_RUN, and it raises the stable flag on that last step. Software polls the status word until it reads stable and then clears the request. Clearing the request, or holding it high, starts no further reload.

The register map uses word addresses, each one a byte offset divided by four. Cluster 0 has its divider word at 0x09E, its force word at 0x0A0 and its request word at 0x0A1. Cluster 1 has the same three words five words higher, at 0x0A3, 0x0A5 and 0x0A6. The shared status word is at 0x325.

Top module: `ckdiv_top`

## Requirements
- R1: With ratio N in effect (1 to 32), cluster c's output `cpu_clk_en[c]` is high for exactly one cycle in every N PLL cycles, so consecutive pulses are N cycles apart.
- R2: Writing the divider word changes only the shadow ratio in bits [5:0]. The output period stays unchanged until a reload commits the new ratio.
- R3: With the force flag clear, a rising edge of the reload request (bit 16 of the request word) commits the shadow ratio only at the end of the current output period. The period in progress therefore completes at its full old length, and no shortened period appears.
- R4: On commit, a shadow ratio of 0 becomes 1 and a shadow ratio above 32 becomes 32.
- R5: `ratio_stable[c]` drops in the cycle after the request rises. It goes high again two PLL cycles after the commit. Bit 0 of the status word reads 1 only when every cluster is stable, and the other status bits read 0.
- R6: A request held high after stability, or cleared afterwards, causes no second reload. A shadow write made while the request is held high does not change the period.
- R7: The divider word reads back bits [5:0]. The force word reads back bit 24 and the request word reads back bit 16. All other bits read 0, and unmapped addresses read 0.
- R8: Cluster 1's registers sit five words above cluster 0's. A reload on one cluster leaves the other cluster's period unchanged.
- R9: After reset both clusters run at ratio RESET_RATIO (4), both stable flags are 1, and the status word reads 1. The divider words read 4, and the force and request words read 0.
- R10: With the force flag set (bit 24 of the force word), the reload commits in the first cycle after the request is seen, and the period in progress is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Shared PLL clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_pll |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cpu_clk_en | output | 2 | Per-cluster divided clock-enable |
| ratio_stable | output | 2 | Per-cluster stable flag |

## Verification
A table of shadow ratios drives the main function. The table includes ratios 1, 2 and 3, the limit 32, zero, and two values above the limit. Each value is first checked to leave the period unchanged, then reloaded and measured. This separates a correct divider from one with an off-by-one period, missing clamping, or a commit on write. The clusters take turns, so any leak between them shows up as a wrong period on the idle cluster.

Three directed cases follow. A 32-to-2 reload is requested just after a pulse, which must produce one full 32-cycle period before the new period of 2. The same kind of request with the force flag set must instead produce a truncated interval of exactly 13 cycles. A request held high through a later shadow write, and then cleared, must leave the ratio untouched.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
    localparam int CKD_RATIO_W  = 6;
    localparam int CKD_MAX      = 32;
    localparam int CKD_NCLUST   = 2;

    typedef enum logic [1:0] {
        DV_RUN      = 2'd0,
        DV_ARMED    = 2'd1,
        DV_SETTLE_A = 2'd2,
        DV_SETTLE_B = 2'd3
    } dv_state_e;
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int NCLUST      = 2,
    parameter int RATIO_W     = 6,
    parameter int RESET_RATIO = 4,
    parameter int DIV_BASE    = 'h09E,
    parameter int FORCE_BASE  = 'h0A0,
    parameter int REQ_BASE    = 'h0A1,
    parameter int CL_STRIDE   = 5,
    parameter int STAT_ADDR   = 'h325,
    parameter int FORCE_BIT   = 24,
    parameter int REQ_BIT     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [NCLUST-1:0]              stable_i,
    output logic [NCLUST-1:0][RATIO_W-1:0] shadow_o,
    output logic [NCLUST-1:0]              force_o,
    output logic [NCLUST-1:0]              req_o
);
    logic [NCLUST-1:0][RATIO_W-1:0] shadow_q;
    logic [NCLUST-1:0]              force_q;
    logic [NCLUST-1:0]              req_q;

    // Data bits with no field behind them are deliberately dropped.
    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    function automatic logic [ADDR_W-1:0] cl_addr(input int base, input int c);
        return ADDR_W'(base + c * CL_STRIDE);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCLUST; c++) begin
                shadow_q[c] <= RATIO_W'(RESET_RATIO);
                force_q[c]  <= 1'b0;
                req_q[c]    <= 1'b0;
            end
        end else if (wr_en) begin
            for (int c = 0; c < NCLUST; c++) begin
                if (addr == cl_addr(DIV_BASE, c))
                    shadow_q[c] <= wr_data[RATIO_W-1:0];
                if (addr == cl_addr(FORCE_BASE, c))
                    force_q[c] <= wr_data[FORCE_BIT];
                if (addr == cl_addr(REQ_BASE, c))
                    req_q[c] <= wr_data[REQ_BIT];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCLUST; c++) begin
            if (addr == cl_addr(DIV_BASE, c))
                rd_data[RATIO_W-1:0] = shadow_q[c];
            if (addr == cl_addr(FORCE_BASE, c))
                rd_data[FORCE_BIT] = force_q[c];
            if (addr == cl_addr(REQ_BASE, c))
                rd_data[REQ_BIT] = req_q[c];
        end
        if (addr == ADDR_W'(STAT_ADDR))
            rd_data[0] = &stable_i;
    end

    assign shadow_o = shadow_q;
    assign force_o  = force_q;
    assign req_o    = req_q;
endmodule

// File: rtl/ckdiv_chan.sv
module ckdiv_chan
    import ckdiv_pkg::*;
#(
    parameter int RATIO_W     = 6,
    parameter int MAX_RATIO   = 32,
    parameter int RESET_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] shadow_i,
    input  logic               force_i,
    input  logic               req_i,
    output logic               clk_en_o,
    output logic               stable_o,
    output logic               commit_o,
    output logic [RATIO_W-1:0] ratio_o
);
    dv_state_e          state_q, state_d;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_q;
    logic [RATIO_W-1:0] pend_q;
    logic               stable_q;
    logic               req_seen_q;
    logic               period_end;
    logic               req_rise;
    logic               commit;

    function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
        if (r == '0)
            return RATIO_W'(1);
        else if (int'(r) > MAX_RATIO)
            return RATIO_W'(MAX_RATIO);
        else
            return r;
    endfunction

    assign period_end = (cnt_q == act_q - RATIO_W'(1));
    assign req_rise   = req_i & ~req_seen_q;
    assign commit     = (state_q == DV_ARMED) && (period_end || force_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_RUN:      if (req_rise) state_d = DV_ARMED;
            DV_ARMED:    if (commit)   state_d = DV_SETTLE_A;
            DV_SETTLE_A: state_d = DV_SETTLE_B;
            DV_SETTLE_B: state_d = DV_RUN;
            default:     state_d = DV_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DV_RUN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            act_q      <= RATIO_W'(RESET_RATIO);
            pend_q     <= RATIO_W'(RESET_RATIO);
            stable_q   <= 1'b1;
            req_seen_q <= 1'b0;
        end else begin
            req_seen_q <= req_i;
            if (commit) begin
                act_q <= pend_q;
                cnt_q <= '0;
            end else if (period_end) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + RATIO_W'(1);
            end
            if (state_q == DV_RUN && req_rise) begin
                pend_q   <= clamp_ratio(shadow_i);
                stable_q <= 1'b0;
            end
            if (state_q == DV_SETTLE_B)
                stable_q <= 1'b1;
        end
    end

    always_comb begin
        clk_en_o = period_end;
        stable_o = stable_q;
        commit_o = commit;
        ratio_o  = act_q;
    end
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
    import ckdiv_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int NCLUST      = CKD_NCLUST,
    parameter int RATIO_W     = CKD_RATIO_W,
    parameter int MAX_RATIO   = CKD_MAX,
    parameter int RESET_RATIO = 4
) (
    input  logic              clk_pll,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCLUST-1:0] cpu_clk_en,
    output logic [NCLUST-1:0] ratio_stable
);
    logic [NCLUST-1:0][RATIO_W-1:0] shadow_w;
    logic [NCLUST-1:0][RATIO_W-1:0] act_w;
    logic [NCLUST-1:0]              force_w;
    logic [NCLUST-1:0]              req_w;
    logic [NCLUST-1:0]              commit_w;

    ckdiv_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCLUST(NCLUST),
        .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
    ) u_regs (
        .clk(clk_pll), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .stable_i(ratio_stable),
        .shadow_o(shadow_w), .force_o(force_w), .req_o(req_w)
    );

    for (genvar c = 0; c < NCLUST; c++) begin : g_chan
        ckdiv_chan #(
            .RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO), .RESET_RATIO(RESET_RATIO)
        ) u_chan (
            .clk(clk_pll), .rst_n(rst_n), .shadow_i(shadow_w[c]),
            .force_i(force_w[c]), .req_i(req_w[c]), .clk_en_o(cpu_clk_en[c]),
            .stable_o(ratio_stable[c]), .commit_o(commit_w[c]), .ratio_o(act_w[c])
        );
    end
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk #(
    parameter int NCLUST    = 2,
    parameter int RATIO_W   = 6,
    parameter int MAX_RATIO = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NCLUST-1:0]              en,
    input logic [NCLUST-1:0]              commit,
    input logic [NCLUST-1:0]              stable,
    input logic [NCLUST-1:0]              req,
    input logic [NCLUST-1:0]              frc,
    input logic [NCLUST-1:0][RATIO_W-1:0] act
);
    for (genvar c = 0; c < NCLUST; c++) begin : g_chk
        // R3
        commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit[c] && !frc[c]) |-> en[c]);
        // R2
        ratio_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] != $past(act[c])) |-> $past(commit[c]));
        // R4
        ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] != '0) && (int'(act[c]) <= MAX_RATIO));
        // R5
        stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit[c] |-> ##3 stable[c]);
        // R5
        stable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit[c] |=> !stable[c]);
        // R5
        stable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(req[c]) && stable[c]) |=> !stable[c]);
    end
endmodule

bind ckdiv_top ckdiv_chk #(
    .NCLUST(NCLUST), .RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO)
) u_chk (
    .clk(clk_pll), .rst_n(rst_n), .en(cpu_clk_en), .commit(commit_w),
    .stable(ratio_stable), .req(req_w), .frc(force_w), .act(act_w)
);

// File: tb/sim_ckdiv_top.sv
`timescale 1ns/1ps
module sim_ckdiv_top;
    logic        clk_pll = 1'b0;
    logic        rst_n   = 1'b0;
    logic        reg_wr  = 1'b0;
    logic [9:0]  reg_addr  = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  cpu_clk_en;
    logic [1:0]  ratio_stable;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int exp_per [2] = '{4, 4};

    localparam int VEC_N = 8;
    localparam logic [5:0] V_RATIO [VEC_N] = '{6'd1, 6'd2, 6'd32, 6'd5, 6'd3, 6'd0, 6'd40, 6'd63};
    localparam int         V_EXP   [VEC_N] = '{1, 2, 32, 5, 3, 1, 32, 32};

    always #10 clk_pll = ~clk_pll;

    ckdiv_top u0 (
        .clk_pll(clk_pll), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_clk_en(cpu_clk_en),
        .ratio_stable(ratio_stable)
    );

    function automatic logic [9:0] a_div(input int c);   return 10'(32'h09E + c * 5); endfunction
    function automatic logic [9:0] a_force(input int c); return 10'(32'h0A0 + c * 5); endfunction
    function automatic logic [9:0] a_req(input int c);   return 10'(32'h0A1 + c * 5); endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk_pll);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk_pll);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk_pll);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic align(input int c);
        int g = 0;
        do begin @(negedge clk_pll); g++; end while (!cpu_clk_en[c] && g < 200);
    endtask

    task automatic measure(input int c, output int p);
        align(c);
        p = 0;
        do begin @(negedge clk_pll); p++; end while (!cpu_clk_en[c] && p < 200);
    endtask

    task automatic wait_stable(input string req);
        logic [31:0] d;
        int g = 0;
        do begin reg_read(10'h325, d); g++; end while (!d[0] && g < 200);
        check(req, int'(d[0]), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk_pll);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int p, n, cl, oth;
        repeat (3) @(negedge clk_pll);
        rst_n = 1'b1;

        // R9 reset state
        check("R9 stable", int'(ratio_stable), 3);
        reg_read(10'h325, d); check("R9 status", int'(d), 1);
        reg_read(a_div(0), d); check("R9 div0", int'(d), 4);
        reg_read(a_req(1), d); check("R9 req1", int'(d), 0);
        measure(0, p); check("R9 period0", p, 4);
        measure(1, p); check("R9 period1", p, 4);

        for (int i = 0; i < VEC_N; i++) begin
            cl = i % 2; oth = 1 - cl;
            reg_write(a_div(cl), {26'd0, V_RATIO[i]});
            measure(cl, p); check("R2 shadow only", p, exp_per[cl]);
            reg_write(a_req(cl), 32'h0001_0000);
            @(negedge clk_pll);
            check("R5 stable drop", int'(ratio_stable[cl]), 0);
            wait_stable("R5 stable rise");
            reg_write(a_req(cl), 32'h0);
            measure(cl, p);
            measure(cl, p);
            if (V_RATIO[i] == 0 || V_RATIO[i] > 32) check("R4 clamp", p, V_EXP[i]);
            else check("R1 period", p, V_EXP[i]);
            exp_per[cl] = V_EXP[i];
            measure(oth, p); check("R8 other cluster", p, exp_per[oth]);
        end

        // R3 non-forced reload waits for end of a full 32 period (cluster 0 at 32)
        reg_write(a_div(0), 32'd2);
        align(0);
        reg_write(a_req(0), 32'h0001_0000);
        n = 2;
        do begin @(negedge clk_pll); n++; end while (!cpu_clk_en[0] && n < 200);
        check("R3 full old period", n, 32);
        n = 0;
        do begin @(negedge clk_pll); n++; end while (!cpu_clk_en[0] && n < 200);
        check("R3 new period", n, 2);
        wait_stable("R5 after R3");
        reg_write(a_req(0), 32'h0);

        // R10 forced reload cuts period short (cluster 1 at 32)
        reg_write(a_force(1), 32'hFFFF_FFFF);
        reg_write(a_div(1), 32'd10);
        align(1);
        reg_write(a_req(1), 32'h0001_0000);
        n = 2;
        do begin @(negedge clk_pll); n++; end while (!cpu_clk_en[1] && n < 200);
        check("R10 forced interval", n, 13);
        wait_stable("R5 after R10");
        reg_write(a_req(1), 32'h0);
        reg_write(a_force(1), 32'h0);
        measure(1, p); check("R10 period", p, 10);

        // R6 held request and later clear cause no reload
        reg_write(a_div(1), 32'd7);
        reg_write(a_req(1), 32'h0001_0000);
        wait_stable("R5 before R6");
        measure(1, p); check("R6 committed", p, 7);
        reg_write(a_div(1), 32'd9);
        repeat (20) @(negedge clk_pll);
        measure(1, p); check("R6 held request", p, 7);
        reg_write(a_req(1), 32'h0);
        repeat (20) @(negedge clk_pll);
        measure(1, p); check("R6 cleared request", p, 7);
        check("R6 stable kept", int'(ratio_stable[1]), 1);

        // R7 readback masking
        reg_read(a_div(1), d); check("R7 div readback", int'(d), 9);
        reg_write(a_force(0), 32'hFFFF_FFFF);
        reg_read(a_force(0), d); check("R7 force readback", int'(d), 32'h0100_0000);
        reg_write(a_force(0), 32'h0);
        reg_write(a_div(0), 32'hFFFF_FFC5);
        reg_read(a_div(0), d); check("R7 div mask", int'(d), 5);
        reg_write(a_req(0), 32'hFFFF_FFFF);
        reg_read(a_req(0), d); check("R7 req readback", int'(d), 32'h0001_0000);
        wait_stable("R5 status word");
        reg_read(10'h325, d); check("R7 status bits", int'(d), 1);
        reg_write(a_req(0), 32'h0);
        reg_read(10'h000, d); check("R7 unmapped", int'(d), 0);
        measure(0, p); check("R1 after readback", p, 5);

        finish_run();
    end
endmodule